// File: doc/BRIEF.md
# Wired-Bounded Random Replacement Index

This block holds the index that a translation buffer uses when software asks for an entry to be replaced at a pseudo-random position. It keeps two 6-bit registers: a floor register and a counter. The counter steps down by one for every retired instruction. When it has reached the floor, the next retired instruction sends it back to the fixed top index, 47, instead of one below the floor.

The counter therefore only ever walks the range from the floor up to 47. Entries below the floor are reserved for mappings that must never be evicted by a random replacement. The floor is written through a small register write port. That port also addresses the counter, but the counter is read-only, so a write aimed at it changes nothing. The current counter value is driven on its own output at all times. A combinational read port returns either register.

Top module: `rnd_index_counter`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the counter is set to 47 and the floor register is set to 0.
- R2: On an edge where `retire` is high, there is no floor write, the floor is at most 47 and the counter is not equal to the floor, the counter decreases by exactly one.
- R3: On an edge with `retire` low and no floor write, both the counter and the floor keep their values.
- R4: On an edge where `retire` is high, there is no floor write, the floor is at most 47 and the counter equals the floor, the counter becomes 47.
- R5: A write with `wr_en`=1 and `wr_sel`=0 stores `wr_data` in the floor register and sets the counter to 47. A floor write takes priority over `retire` in the same cycle.
- R6: While the floor register holds a value above 47, the counter stays at 47 whatever `retire` does.
- R7: A write with `wr_en`=1 and `wr_sel`=1 addresses the counter and is ignored. Neither the counter nor the floor changes, apart from the counter step that `retire` causes in that same cycle.
- R8: `rd_data` combinationally returns the floor register when `rd_sel`=0 and the counter when `rd_sel`=1. `rnd_idx` always shows the counter.
- R9: Outside reset, the counter always lies between the floor and 47 inclusive when the floor is at most 47.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| retire | input | 1 | One pulse per retired instruction |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | Write target: 0 = floor register, 1 = counter (ignored) |
| wr_data | input | 6 | Write data |
| rd_sel | input | 1 | Read target: 0 = floor register, 1 = counter |
| rd_data | output | 6 | Selected register value |
| rnd_idx | output | 6 | Current replacement index |
| wired_q | output | 6 | Current floor value |

## Verification
The counter is driven down across a narrow floor range several times. This separates a plain decrement from the reload to 47 at the floor, and it shows whether the floor is compared before or after the step. Idle cycles and writes aimed at the read-only counter show that nothing moves without a retire. A floor write in the same cycle as a retire shows which of the two wins. Floors of 47 and above 47, and a full sweep with a floor of 0, cover the degenerate single-entry range, the out-of-range floor and the full 48-step period.

// File: rtl/rnd_index_counter.sv
module rnd_index_counter #(
  parameter int IDX_W   = 6,
  parameter int TOP_IDX = 47
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             retire,
  input  logic             wr_en,
  input  logic             wr_sel,
  input  logic [IDX_W-1:0] wr_data,
  input  logic             rd_sel,
  output logic [IDX_W-1:0] rd_data,
  output logic [IDX_W-1:0] rnd_idx,
  output logic [IDX_W-1:0] wired_q
);
  localparam logic [IDX_W-1:0] TOP_V = IDX_W'(TOP_IDX);

  logic floor_wr, floor_bad, at_floor;

  assign floor_wr  = wr_en && !wr_sel;
  assign floor_bad = wired_q > TOP_V;
  assign at_floor  = rnd_idx == wired_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rnd_idx <= TOP_V;
      wired_q <= '0;
    end else if (floor_wr) begin
      wired_q <= wr_data;
      rnd_idx <= TOP_V;
    end else if (retire) begin
      if (floor_bad || at_floor) rnd_idx <= TOP_V;
      else                       rnd_idx <= rnd_idx - 1'b1;
    end
  end

  assign rd_data = rd_sel ? rnd_idx : wired_q;
endmodule

// File: rtl/rnd_index_counter_chk.sv
module rnd_index_counter_chk #(
  parameter int IDX_W   = 6,
  parameter int TOP_IDX = 47
) (
  input logic             clk,
  input logic             rst_n,
  input logic             retire,
  input logic             wr_en,
  input logic             wr_sel,
  input logic [IDX_W-1:0] wr_data,
  input logic             rd_sel,
  input logic [IDX_W-1:0] rd_data,
  input logic [IDX_W-1:0] rnd_idx,
  input logic [IDX_W-1:0] wired_q
);
  localparam logic [IDX_W-1:0] TOP_V = IDX_W'(TOP_IDX);

  p_reset_val_r1: assert property (@(posedge clk)
    !rst_n |=> (rnd_idx == TOP_V && wired_q == '0));

  p_step_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !(wr_en && !wr_sel) && wired_q <= TOP_V && rnd_idx != wired_q)
    |=> rnd_idx == $past(rnd_idx) - 1'b1);

  p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!retire && !(wr_en && !wr_sel)) |=> ($stable(rnd_idx) && $stable(wired_q)));

  p_wrap_top_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire && !(wr_en && !wr_sel) && wired_q <= TOP_V && rnd_idx == wired_q)
    |=> rnd_idx == TOP_V);

  p_floor_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_sel) |=> (wired_q == $past(wr_data) && rnd_idx == TOP_V));

  p_big_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wired_q > TOP_V) |-> rnd_idx == TOP_V);

  p_read_mux_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data == (rd_sel ? rnd_idx : wired_q));

  p_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wired_q <= TOP_V) |-> (rnd_idx >= wired_q && rnd_idx <= TOP_V));
endmodule

bind rnd_index_counter rnd_index_counter_chk #(.IDX_W(IDX_W), .TOP_IDX(TOP_IDX)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire(retire), .wr_en(wr_en), .wr_sel(wr_sel),
  .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .rnd_idx(rnd_idx),
  .wired_q(wired_q)
);

// File: tb/rnd_index_counter_test.sv
module rnd_index_counter_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       retire = 1'b0, wr_en = 1'b0, wr_sel = 1'b0, rd_sel = 1'b0;
  logic [5:0] wr_data = '0;
  logic [5:0] rd_data, rnd_idx, wired_q;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  rnd_index_counter uut (
    .clk(clk), .rst_n(rst_n), .retire(retire), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data), .rnd_idx(rnd_idx),
    .wired_q(wired_q)
  );

  // {retire, wr_en, wr_sel, wr_data, expected counter, expected floor}
  localparam int NV = 18;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b1, 1'b0, 6'd44, 6'd47, 6'd44},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd46, 6'd44},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd45, 6'd44},
    {1'b0, 1'b0, 1'b0, 6'd0,  6'd45, 6'd44},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd44, 6'd44},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd47, 6'd44},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd46, 6'd44},
    {1'b0, 1'b1, 1'b1, 6'd5,  6'd46, 6'd44},
    {1'b1, 1'b1, 1'b0, 6'd45, 6'd47, 6'd45},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd46, 6'd45},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd45, 6'd45},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd47, 6'd45},
    {1'b0, 1'b1, 1'b0, 6'd47, 6'd47, 6'd47},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd47, 6'd47},
    {1'b0, 1'b1, 1'b0, 6'd60, 6'd47, 6'd60},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd47, 6'd60},
    {1'b0, 1'b1, 1'b0, 6'd0,  6'd47, 6'd0},
    {1'b1, 1'b0, 1'b0, 6'd0,  6'd46, 6'd0}
  };

  task automatic chk(input string tag, input logic [5:0] got, input logic [5:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, got, exp);
    end
  endtask

  task automatic step(input logic r, input logic we, input logic sel, input logic [5:0] d);
    @(negedge clk);
    retire = r; wr_en = we; wr_sel = sel; wr_data = d;
    @(posedge clk);
    #1;
    retire = 1'b0; wr_en = 1'b0; wr_sel = 1'b0;
  endtask

  initial begin
    #(5.0 * 20000);
    errors++;
    $display("FAIL watchdog: run did not finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    string tag;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 counter", rnd_idx, 6'd47);
    chk("R1 floor", wired_q, 6'd0);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      logic [20:0] v;
      v = VEC[i];
      step(v[20], v[19], v[18], v[17:12]);
      if (v[19] && !v[18])  tag = "R5";
      else if (v[19])       tag = "R7";
      else if (!v[20])      tag = "R3";
      else if (v[5:0] > 6'd47) tag = "R6";
      else if (v[11:6] == 6'd47) tag = "R4";
      else                  tag = "R2";
      chk({tag, " counter"}, rnd_idx, v[11:6]);
      chk({tag, " floor"}, wired_q, v[5:0]);
    end

    // R8: read port selects
    rd_sel = 1'b1; #1;
    chk("R8 read counter", rd_data, 6'd46);
    rd_sel = 1'b0; #1;
    chk("R8 read floor", rd_data, 6'd0);
    chk("R8 index output", rnd_idx, 6'd46);

    // R2/R4/R9: full sweep with floor 0, period 48
    step(1'b0, 1'b1, 1'b0, 6'd0);
    for (int k = 1; k <= 47; k++) begin
      step(1'b1, 1'b0, 1'b0, 6'd0);
      if (rnd_idx !== 6'(47 - k)) chk("R2 sweep", rnd_idx, 6'(47 - k));
    end
    chk("R9 sweep bottom", rnd_idx, 6'd0);
    step(1'b1, 1'b0, 1'b0, 6'd0);
    chk("R4 sweep wrap", rnd_idx, 6'd47);

    // R7: write to counter with retire still steps normally, floor untouched
    step(1'b1, 1'b1, 1'b1, 6'd3);
    chk("R7 counter", rnd_idx, 6'd46);
    chk("R7 floor", wired_q, 6'd0);

    // R1: reset in mid-run
    step(1'b0, 1'b1, 1'b0, 6'd20);
    step(1'b1, 1'b0, 1'b0, 6'd0);
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk); #1;
    chk("R1 mid counter", rnd_idx, 6'd47);
    chk("R1 mid floor", wired_q, 6'd0);
    @(negedge clk); rst_n = 1'b1;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule